// File: doc/BRIEF.md
# Serial Character Transmitter with Line Break

The block serialises characters onto a single output line. A character is written into a one-entry holding register, moved into a shift register when the engine is free, and sent least significant bit first. The frame is a low start bit, then seven or eight data bits, then an optional parity bit, then a high stop bit. Bit timing comes from a one-cycle baud tick supplied from outside, and each tick moves the line to the next bit.

The block can also hold the line low as a break. A start-break command waits until any character in flight has finished. The line then goes low for at least one frame time in the current format. A stop-break command ends the low period, but never before that minimum has elapsed. The line then stays high for twelve tick periods before any further character is sent. Commands that arrive at the wrong moment are ignored by fixed rules, so the break sequence cannot be corrupted from outside.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `txd`, `tx_ready` and `tx_empty` are all 1.
- R2: A frame is sent as a start bit of 0, then the data bits LSB first (8 bits when `cfg_eight`=1, otherwise the low 7), then a parity bit if `cfg_par_en`=1, then a stop bit of 1. Each bit stays on the line until the next baud tick. Even parity (`cfg_par_odd`=0) makes the count of ones across data and parity even. Odd parity (`cfg_par_odd`=1) makes it odd.
- R3: While the holding register is full, `tx_ready` is 0 and a write is discarded. `tx_empty` is 0 from the cycle after a write until that frame's stop bit has ended.
- R4: An accepted start-break lets the current frame finish intact. The line then goes low, and `tx_empty` is 0 while it is low.
- R5: An accepted start-break holds `tx_ready` at 0 until the line goes low. Writes made during that wait are discarded.
- R6: The break stays low for at least L tick periods, where L is the frame length (9 + `cfg_eight` + `cfg_par_en`). When stop-break arrives early, the line is low for exactly L ticks.
- R7: After the low period, the line is high for exactly 12 ticks with `tx_empty`=0. A character written during those 12 ticks starts only after them.
- R8: A stop-break given while no break is low is ignored.
- R9: A start-break given while a break is pending, low, or in its 12-tick tail is ignored.
- R10: A start-break and a stop-break in the same cycle are both ignored.
- R11: Writes made while the line is held low by a break are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle bit-period strobe |
| cfg_eight | input | 1 | 1 = eight data bits, 0 = seven |
| cfg_par_en | input | 1 | 1 = append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| brk_start | input | 1 | Start-break command strobe |
| brk_stop | input | 1 | Stop-break command strobe |
| tx_ready | output | 1 | Holding register can take a write |
| tx_empty | output | 1 | Nothing held, shifting, or in a break |
| txd | output | 1 | Serial line, idle high |

## Verification
The hardest case is a break whose command lands while a character is still shifting. The bench has to check that the character comes out whole, that the low period is exactly one frame long, and that stray writes and commands issued during the break leave no trace. The directed stimulus waits for the start bit and then issues start-break. A parallel thread watches `tx_ready` to tell when the break has begun. That thread then issues a discarded write, a redundant start-break and an early stop-break. Meanwhile a monitor counts the low ticks and the tail ticks. A second scenario gives stop-break late and queues a character inside the tail.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  localparam int DATA_W    = 8;
  localparam int FRAME_MAX = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_BRK, ST_TAIL} eng_st_t;

  // Frame length in bit periods: start + data + parity + stop
  function automatic logic [3:0] frame_len(input logic eight, input logic par);
    return 4'd9 + {3'd0, eight} + {3'd0, par};
  endfunction

  function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic eight,
                                   input logic odd);
    return (^d[DATA_W-2:0]) ^ (eight & d[DATA_W-1]) ^ odd;
  endfunction

  // Whole frame, bit 0 first on the line, unused upper bits idle high
  function automatic logic [FRAME_MAX-1:0] frame_word(input logic [DATA_W-1:0] d,
      input logic eight, input logic par, input logic odd);
    logic [FRAME_MAX-1:0] w;
    w = '1;
    w[0] = 1'b0;
    w[DATA_W-1:1] = d[DATA_W-2:0];
    if (eight) begin
      w[DATA_W] = d[DATA_W-1];
      if (par) w[DATA_W+1] = par_bit(d, eight, odd);
    end else if (par) begin
      w[DATA_W] = par_bit(d, eight, odd);
    end
    return w;
  endfunction
endpackage

// File: rtl/txb_hold.sv
module txb_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (take) begin
      valid <= 1'b0;
    end else if (wr_acc) begin
      valid <= 1'b1;
      data  <= wr_data;
    end
  end

  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !wr_acc);
endmodule

// File: rtl/txb_brk_cmd.sv
module txb_brk_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_start,
  input  logic brk_stop,
  input  logic tx_ready,
  input  logic brk_low,
  input  logic brk_tail,
  input  logic brk_begin,
  input  logic tail_enter,
  output logic brk_pend,
  output logic stop_req,
  output logic start_acc
);
  logic stop_acc;

  // Same-cycle start and stop cancel each other out
  assign start_acc = brk_start & ~brk_stop & tx_ready & ~brk_pend & ~brk_low & ~brk_tail;
  assign stop_acc  = brk_stop & ~brk_start & tx_ready & brk_low & ~stop_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_pend <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      if (brk_begin)      brk_pend <= 1'b0;
      else if (start_acc) brk_pend <= 1'b1;
      if (tail_enter)     stop_req <= 1'b0;
      else if (stop_acc)  stop_req <= 1'b1;
    end
  end

  a_r10_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_start && brk_stop && !brk_begin && !tail_enter) |=> ($stable(brk_pend) && $stable(stop_req)));
  a_r8_stop_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(brk_low));
  a_r9_single_break: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pend |-> (!brk_low && !brk_tail));
endmodule

// File: rtl/txb_engine.sv
module txb_engine
  import uart_brk_pkg::*;
#(
  parameter int TAIL_TICKS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_eight,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              brk_pend,
  input  logic              stop_req,
  output logic              txd,
  output logic              eng_idle,
  output logic              brk_low,
  output logic              brk_tail,
  output logic              brk_begin,
  output logic              tail_enter,
  output logic              load
);
  localparam int CNT_MAX = (TAIL_TICKS > FRAME_MAX) ? TAIL_TICKS : FRAME_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  eng_st_t              st;
  logic [FRAME_MAX-1:0] shreg;
  logic [CNT_W-1:0]     cnt, len_q;
  logic                 low_done;

  assign eng_idle   = (st == ST_IDLE);
  assign brk_low    = (st == ST_BRK);
  assign brk_tail   = (st == ST_TAIL);
  assign brk_begin  = eng_idle & brk_pend;
  assign load       = eng_idle & hold_valid & ~brk_pend;
  assign low_done   = (cnt >= len_q);
  assign tail_enter = brk_low & stop_req & low_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      shreg <= '1;
      cnt   <= '0;
      len_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt   <= '0;
          len_q <= CNT_W'(frame_len(cfg_eight, cfg_par_en));
          if (brk_begin) begin
            st <= ST_BRK;
          end else if (load) begin
            st    <= ST_SEND;
            shreg <= frame_word(hold_data, cfg_eight, cfg_par_en, cfg_par_odd);
          end
        end
        ST_SEND: if (baud_tick) begin
          shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
          if (cnt == len_q - CNT_W'(1)) st <= ST_IDLE;
          else                          cnt <= cnt + CNT_W'(1);
        end
        ST_BRK: begin
          if (tail_enter) begin
            st  <= ST_TAIL;
            cnt <= '0;
          end else if (baud_tick && !low_done) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_TAIL: if (baud_tick) begin
          if (cnt == CNT_W'(TAIL_TICKS - 1)) st <= ST_IDLE;
          else                               cnt <= cnt + CNT_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_SEND: txd = shreg[0];
      ST_BRK:  txd = 1'b0;
      default: txd = 1'b1;
    endcase
  end

  a_r4_break_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_low) |-> $past(eng_idle));
  a_r6_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_low) |-> ($past(cnt) >= $past(len_q)));
  a_r7_tail_high: assert property (@(posedge clk) disable iff (!rst_n)
    brk_tail |-> txd);
  a_r11_no_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk_low |-> !hold_valid);
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int TAIL_TICKS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_eight,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_start,
  input  logic              brk_stop,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic              txd
);
  logic              hold_valid, brk_pend, stop_req, start_acc, wr_acc;
  logic              eng_idle, brk_low, brk_tail, brk_begin, tail_enter, load;
  logic [DATA_W-1:0] hold_data;

  assign tx_ready = ~hold_valid & ~brk_pend;
  assign tx_empty = eng_idle & ~hold_valid & ~brk_pend;
  // Writes lose to a break accepted in the same cycle and to an active low period
  assign wr_acc   = wr_en & tx_ready & ~brk_low & ~start_acc;

  txb_hold #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_data(wr_data),
    .take(load), .valid(hold_valid), .data(hold_data));

  txb_brk_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .brk_start(brk_start), .brk_stop(brk_stop),
    .tx_ready(tx_ready), .brk_low(brk_low), .brk_tail(brk_tail),
    .brk_begin(brk_begin), .tail_enter(tail_enter),
    .brk_pend(brk_pend), .stop_req(stop_req), .start_acc(start_acc));

  txb_engine #(.TAIL_TICKS(TAIL_TICKS)) u_eng (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_eight(cfg_eight), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .hold_valid(hold_valid), .hold_data(hold_data),
    .brk_pend(brk_pend), .stop_req(stop_req),
    .txd(txd), .eng_idle(eng_idle), .brk_low(brk_low), .brk_tail(brk_tail),
    .brk_begin(brk_begin), .tail_enter(tail_enter), .load(load));

  a_r5_pend_drops_writes: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pend |=> !$rose(hold_valid));
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);
endmodule

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic wr_en = 1'b0, brk_start = 1'b0, brk_stop = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_ready, tx_empty, txd;
  int n_tests = 0, n_fail = 0;
  int tick_div = 0;

  uart_brk_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_eight(cfg_eight),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .wr_en(wr_en),
    .wr_data(wr_data), .brk_start(brk_start), .brk_stop(brk_stop),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .txd(txd));

  always #4 clk = ~clk;

  // One tick every four clocks, changed just after the rising edge
  always @(posedge clk) begin
    #1;
    tick_div = (tick_div == 3) ? 0 : tick_div + 1;
    baud_tick = (tick_div == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input bit e, input bit p);
    return 2 + (e ? 8 : 7) + (p ? 1 : 0);
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input bit e,
                                            input bit p, input bit o);
    logic [10:0] f;
    int nd, ones;
    nd = e ? 8 : 7;
    ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      if (d[i]) ones++;
    end
    if (p) f[nd+1] = o ? ((ones % 2) == 0) : ((ones % 2) == 1);
    return f;
  endfunction

  task automatic pulse_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic pulse_start;
    brk_start = 1'b1; @(negedge clk); brk_start = 1'b0;
  endtask
  task automatic pulse_stop;
    brk_stop = 1'b1; @(negedge clk); brk_stop = 1'b0;
  endtask
  task automatic pulse_both;
    brk_start = 1'b1; brk_stop = 1'b1; @(negedge clk);
    brk_start = 1'b0; brk_stop = 1'b0;
  endtask

  task automatic next_tick;
    do @(negedge clk); while (!baud_tick);
  endtask

  task automatic check_frame(input logic [7:0] d, input string req);
    logic [10:0] got, exp, mask;
    int len;
    len = exp_len(cfg_eight, cfg_par_en);
    exp = exp_frame(d, cfg_eight, cfg_par_en, cfg_par_odd);
    mask = 11'h7FF >> (11 - len);
    got = '1;
    while (!(baud_tick && txd == 1'b0)) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < len; i++) begin
      next_tick();
      got[i] = txd;
    end
    chk(((got ^ exp) & mask) == 11'd0, req, int'(got & mask), int'(exp & mask));
  endtask

  task automatic measure_break(output int low, output int tail, output bit empty_low);
    low = 0; tail = 0;
    while (!(baud_tick && txd == 1'b0)) @(negedge clk);
    empty_low = !tx_empty;
    forever begin
      if (baud_tick) begin
        if (!txd) low++;
        else break;
      end
      @(negedge clk);
    end
    forever begin
      if (baud_tick) begin
        if (txd && !tx_empty) tail++;
        else break;
      end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int nticks, input string req);
    for (int i = 0; i < nticks; i++) begin
      next_tick();
      chk(txd && tx_empty, req, {txd, tx_empty}, 3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lo, tl;
    bit el;
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd && tx_ready && tx_empty, "R1", {txd, tx_ready, tx_empty}, 7);

    // R3: second write while full is dropped
    pulse_wr(8'hA5);
    chk(!tx_ready && !tx_empty, "R3", {tx_ready, tx_empty}, 0);
    pulse_wr(8'h5A);
    check_frame(8'hA5, "R2");
    quiet(15, "R3");

    // R2: directed formats
    cfg_eight = 0; cfg_par_en = 1; cfg_par_odd = 0; pulse_wr(8'h3C); check_frame(8'h3C, "R2");
    cfg_eight = 1; cfg_par_en = 1; cfg_par_odd = 1; pulse_wr(8'h80); check_frame(8'h80, "R2");
    cfg_eight = 0; cfg_par_en = 1; cfg_par_odd = 1; pulse_wr(8'hFF); check_frame(8'hFF, "R2");
    cfg_eight = 1; cfg_par_en = 1; cfg_par_odd = 0; pulse_wr(8'h00); check_frame(8'h00, "R2");
    // R2: random formats and data
    for (int k = 0; k < 30; k++) begin
      d = 8'($urandom);
      cfg_eight = 1'($urandom); cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
      pulse_wr(d);
      check_frame(d, "R2");
    end
    quiet(2, "R3");

    // Break issued mid-frame, early stop (R4 R5 R6 R7 R9 R11)
    cfg_eight = 1; cfg_par_en = 1; cfg_par_odd = 0;
    pulse_wr(8'hC3);
    while (txd) @(negedge clk);
    pulse_start();
    chk(!tx_ready, "R5", tx_ready, 0);
    pulse_wr(8'hFF);
    fork
      begin
        check_frame(8'hC3, "R4");
        measure_break(lo, tl, el);
      end
      begin
        while (!tx_ready) @(negedge clk);
        pulse_wr(8'h11);
        pulse_start();
        pulse_stop();
      end
    join
    chk(el, "R4", el, 1);
    chk(lo == 11, "R6", lo, 11);
    chk(tl == 12, "R7", tl, 12);
    quiet(20, "R5/R9/R11");

    // Late stop, start and write inside the tail (R6 R7 R9)
    cfg_eight = 0; cfg_par_en = 0;
    pulse_start();
    fork
      begin
        measure_break(lo, tl, el);
        check_frame(8'h4E, "R7");
      end
      begin
        repeat (27) next_tick();
        pulse_stop();
        while (!txd) @(negedge clk);
        next_tick(); next_tick();
        pulse_start();
        pulse_wr(8'h4E);
      end
    join
    chk(lo >= 9 && lo <= 28, "R6", lo, 27);
    chk(tl == 12, "R7", tl, 12);
    quiet(20, "R9");

    // R8: stop with no break
    pulse_stop();
    chk(tx_ready, "R8", tx_ready, 1);
    quiet(16, "R8");
    pulse_wr(8'h96); check_frame(8'h96, "R8");
    quiet(2, "R8");

    // R10: simultaneous commands, idle and during a break
    pulse_both();
    chk(tx_ready, "R10", tx_ready, 1);
    quiet(16, "R10");
    pulse_start();
    while (!tx_ready) @(negedge clk);
    pulse_both();
    repeat (30) next_tick();
    chk(txd == 1'b0, "R10", txd, 0);
    pulse_stop();
    while (!tx_empty) @(negedge clk);
    quiet(4, "R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule